// File: doc/BRIEF.md
# Receiver Lock and Mute Sequencer

This controller decides which clocks and data a serial digital audio receiver presents while the input stream comes and goes. Out of reset no stream is present. The output audio clocks then come from a local free-running source, and its rate is set by a three-bit strap. The block counts rising edges on the serial audio line. Once enough edges have arrived, it mutes the data output and waits for the analog PLL to report lock. When lock arrives, it switches the clocks over to the recovered source and releases the mute.

If the line goes quiet for a set number of reference cycles, the sequencer returns to the free-running source. It then runs at the rate that was being tracked during lock rather than at the strap default. It also raises the unlock status pin, but only on a transition of the output frame clock, so that downstream logic sees the flag aligned to a frame boundary. If lock never arrives, a timeout of one millisecond of reference cycles sends the sequencer back to edge counting.

The line and frame clock inputs are asynchronous and pass through synchronizers. The PLL flag and the tracked rate code are taken as already in the reference domain.

Top module: `rx_lock_seq`

## Requirements
- R1: Out of reset, unlock is 1, data_mute is 1 and clk_src_recovered is 0. Unlock stays 1 until the sequencer first reaches lock.
- R2: With no lock yet, free_rate decodes rate_strap. Strap 0 gives code 0 (48 kHz). Straps 1, 2, 3 and 4 give codes 1 (32 kHz), 2 (44.1 kHz), 3 (88.2 kHz) and 4 (96 kHz). Straps 5 to 7 count as open and give code 0.
- R3: With fewer than EDGE_MIN rising edges seen on serial_in, a high pll_locked does not unmute the output and does not select the recovered clock.
- R4: After EDGE_MIN rising edges with pll_locked high, the block reaches lock: data_mute is 0, clk_src_recovered is 1 and unlock is 0.
- R5: After the input is detected, data_mute stays 1 for as long as pll_locked stays low.
- R6: If lock does not arrive within REF_HZ/1000 reference cycles of detection, the sequencer returns to edge counting. A later pll_locked then has no effect until EDGE_MIN new edges have arrived.
- R7: While locked, LOSS_CYC reference cycles without an edge on serial_in bring data_mute to 1 and clk_src_recovered to 0.
- R8: After loss of input, unlock rises only on a transition of frame_clk. While frame_clk holds still, unlock stays 0.
- R9: After a loss, free_rate holds the tracked_rate value captured while locked, whatever the strap says.
- R10: A drop of pll_locked while locked mutes the data and selects the free clock. A return of pll_locked relocks the block without a new round of edge counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_in | input | 1 | Serial audio line (asynchronous) |
| pll_locked | input | 1 | Analog PLL lock flag, reference domain |
| rate_strap | input | 3 | Default free-running rate strap |
| tracked_rate | input | 3 | Rate code from the frequency estimator |
| frame_clk | input | 1 | Output frame clock (asynchronous) |
| clk_src_recovered | output | 1 | 1 selects recovered clocks, 0 the free-running source |
| free_rate | output | 3 | Rate code for the free-running clock source |
| data_mute | output | 1 | 1 forces the audio data output low |
| unlock | output | 1 | Unlock status pin |

## Verification
The bench builds the block with REF_HZ = 40000, which makes the lock timeout 40 cycles, and with LOSS_CYC = 96. EDGE_MIN keeps its default of 10 and HOLD_TRACKED is 1. These values bring the timeout within reach: it can expire while a burst of ten edges still stays well inside the loss window, so the return to edge counting is told apart from a loss. The loss itself is then reachable within a few hundred cycles, and so is the rate hold that follows it.

// File: rtl/rxls_pkg.sv
package rxls_pkg;

   typedef enum logic [2:0] {
      IDLE_FREE      = 3'd0,
      DETECT         = 3'd1,
      MUTE_WAIT_LOCK = 3'd2,
      LOCKED         = 3'd3,
      HOLD_LAST      = 3'd4
   } seq_state_t;

   // rate codes: 0=48k 1=32k 2=44.1k 3=88.2k 4=96k
   localparam logic [2:0] RATE_48K = 3'd0;

   function automatic logic [2:0] strap_to_rate(input logic [2:0] strap);
      logic [2:0] r;
      if (strap <= 3'd4) r = strap;
      else               r = RATE_48K;
      return r;
   endfunction

endpackage

// File: rtl/rxls_sync.sv
module rxls_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   initial begin
      assert (STAGES >= 2) else $error("rxls_sync: STAGES must be >= 2");
      assert (WIDTH >= 1)  else $error("rxls_sync: WIDTH must be >= 1");
   end

   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-2:0], d[b]};
      end
      assign q[b] = chain[STAGES-1];
   end
endmodule

// File: rtl/rxls_activity.sv
module rxls_activity #(
   parameter int LOSS_CYC = 1024
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_lvl,
   output logic rise,
   output logic silent
);
   localparam int CW = $clog2(LOSS_CYC + 1);
   localparam logic [CW-1:0] LIMIT = CW'(LOSS_CYC);

   logic          prev_q;
   logic [CW-1:0] quiet_q;

   initial assert (LOSS_CYC >= 2) else $error("rxls_activity: LOSS_CYC must be >= 2");

   assign rise   = line_lvl & ~prev_q;
   assign silent = (quiet_q == LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         quiet_q <= '0;
      end else begin
         prev_q <= line_lvl;
         if (rise)         quiet_q <= '0;
         else if (!silent) quiet_q <= quiet_q + 1'b1;
      end
   end
endmodule

// File: rtl/rxls_fsm.sv
module rxls_fsm
   import rxls_pkg::*;
#(
   parameter int EDGE_MIN = 10,
   parameter int TMO_CYC  = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rise,
   input  logic       silent,
   input  logic       pll_locked,
   output seq_state_t state,
   output logic       leaving_lock,
   output logic       ever_locked
);
   localparam int EW = $clog2(EDGE_MIN + 1);
   localparam int TW = $clog2(TMO_CYC + 1);
   localparam logic [EW-1:0] EDGE_LAST = EW'(EDGE_MIN - 1);
   localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_CYC - 1);

   initial begin
      assert (EDGE_MIN >= 1) else $error("rxls_fsm: EDGE_MIN must be >= 1");
      assert (TMO_CYC >= 2)  else $error("rxls_fsm: TMO_CYC must be >= 2");
   end

   seq_state_t    st_q, st_d;
   logic [EW-1:0] edges_q;
   logic [TW-1:0] tmo_q;
   logic          ever_q;
   seq_state_t    after_quiet;
   seq_state_t    after_first;

   assign after_quiet = ever_q ? HOLD_LAST : IDLE_FREE;
   assign after_first = (EDGE_MIN <= 1) ? MUTE_WAIT_LOCK : DETECT;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         IDLE_FREE, HOLD_LAST:
            if (rise) st_d = after_first;
         DETECT:
            if (rise && edges_q >= EDGE_LAST) st_d = MUTE_WAIT_LOCK;
            else if (silent)                  st_d = after_quiet;
         MUTE_WAIT_LOCK:
            if (pll_locked)              st_d = LOCKED;
            else if (silent)             st_d = after_quiet;
            else if (tmo_q == TMO_LAST)  st_d = DETECT;
         LOCKED:
            if (silent)           st_d = HOLD_LAST;
            else if (!pll_locked) st_d = MUTE_WAIT_LOCK;
         default: st_d = IDLE_FREE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= IDLE_FREE;
         edges_q <= '0;
         tmo_q   <= '0;
         ever_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (st_d == DETECT && st_q != DETECT) edges_q <= rise ? EW'(1) : '0;
         else if (st_q == DETECT && rise)      edges_q <= edges_q + 1'b1;
         if (st_q == MUTE_WAIT_LOCK && st_d == MUTE_WAIT_LOCK) tmo_q <= tmo_q + 1'b1;
         else                                                  tmo_q <= '0;
         if (st_q == LOCKED) ever_q <= 1'b1;
      end
   end

   assign state        = st_q;
   assign leaving_lock = (st_q == LOCKED) && (st_d != LOCKED);
   assign ever_locked  = ever_q;
endmodule

// File: rtl/rxls_unlock.sv
module rxls_unlock (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_lvl,
   input  logic in_lock,
   input  logic leaving_lock,
   output logic frame_edge,
   output logic unlock
);
   logic frame_prev_q, pend_q, unlock_q;

   assign frame_edge = frame_lvl ^ frame_prev_q;
   assign unlock     = unlock_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame_prev_q <= 1'b0;
         pend_q       <= 1'b0;
         unlock_q     <= 1'b1;
      end else begin
         frame_prev_q <= frame_lvl;
         if (leaving_lock) begin
            pend_q <= 1'b1;
         end else if (in_lock) begin
            pend_q   <= 1'b0;
            unlock_q <= 1'b0;
         end else if (pend_q && frame_edge) begin
            pend_q   <= 1'b0;
            unlock_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_lock_seq.sv
module rx_lock_seq
   import rxls_pkg::*;
#(
   parameter int REF_HZ       = 24_576_000,
   parameter int EDGE_MIN     = 10,
   parameter int LOSS_CYC     = 1024,
   parameter int SYNC_STAGES  = 2,
   parameter bit HOLD_TRACKED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       serial_in,
   input  logic       pll_locked,
   input  logic [2:0] rate_strap,
   input  logic [2:0] tracked_rate,
   input  logic       frame_clk,
   output logic       clk_src_recovered,
   output logic [2:0] free_rate,
   output logic       data_mute,
   output logic       unlock
);
   localparam int TMO_CYC = REF_HZ / 1000;

   initial assert (REF_HZ >= 2000) else $error("rx_lock_seq: REF_HZ too small");

   logic [1:0] async_in, async_q;
   logic       line_lvl, frame_lvl;
   logic       rise, silent, leaving_lock, ever_locked, frame_edge;
   seq_state_t st;

   assign async_in  = {frame_clk, serial_in};
   assign line_lvl  = async_q[0];
   assign frame_lvl = async_q[1];

   rxls_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(async_in), .q(async_q)
   );

   rxls_activity #(.LOSS_CYC(LOSS_CYC)) i_act (
      .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl), .rise(rise), .silent(silent)
   );

   rxls_fsm #(.EDGE_MIN(EDGE_MIN), .TMO_CYC(TMO_CYC)) i_fsm (
      .clk(clk), .rst_n(rst_n), .rise(rise), .silent(silent),
      .pll_locked(pll_locked), .state(st), .leaving_lock(leaving_lock),
      .ever_locked(ever_locked)
   );

   rxls_unlock i_unl (
      .clk(clk), .rst_n(rst_n), .frame_lvl(frame_lvl), .in_lock(st == LOCKED),
      .leaving_lock(leaving_lock), .frame_edge(frame_edge), .unlock(unlock)
   );

   if (HOLD_TRACKED) begin : g_hold
      logic [2:0] held_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            held_q <= RATE_48K;
         else if (st == LOCKED) held_q <= tracked_rate;
      end
      assign free_rate = ever_locked ? held_q : strap_to_rate(rate_strap);
   end else begin : g_snap
      logic unused_ok;
      assign unused_ok = ^{tracked_rate, ever_locked};
      assign free_rate = strap_to_rate(rate_strap);
   end

   assign clk_src_recovered = (st == LOCKED);
   assign data_mute         = (st != LOCKED);
endmodule

// File: rtl/rx_lock_seq_chk.sv
module rx_lock_seq_chk
   import rxls_pkg::*;
#(
   parameter int TMO_CYC = 1000
) (
   input logic       clk,
   input logic       rst_n,
   input seq_state_t st,
   input logic       pll_locked,
   input logic       frame_edge,
   input logic       clk_src_recovered,
   input logic [2:0] free_rate,
   input logic       data_mute,
   input logic       unlock
);
   localparam int CW = $clog2(TMO_CYC + 2);
   logic [CW-1:0] wait_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   wait_cnt <= '0;
      else if (st == MUTE_WAIT_LOCK) wait_cnt <= wait_cnt + 1'b1;
      else                          wait_cnt <= '0;
   end

   a_r6_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      wait_cnt <= CW'(TMO_CYC));

   a_r4_unmute_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_mute) |-> $past(pll_locked));

   a_r7_recovered_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
      clk_src_recovered |-> !data_mute);

   a_r8_unlock_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlock) |-> $past(frame_edge));

   a_r1_unlock_clears_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unlock) |-> $past(!data_mute));

   a_r9_rate_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st == HOLD_LAST && $past(st == HOLD_LAST)) |-> $stable(free_rate));
endmodule

bind rx_lock_seq rx_lock_seq_chk #(.TMO_CYC(TMO_CYC)) i_chk (
   .clk(clk), .rst_n(rst_n), .st(st), .pll_locked(pll_locked),
   .frame_edge(frame_edge), .clk_src_recovered(clk_src_recovered),
   .free_rate(free_rate), .data_mute(data_mute), .unlock(unlock)
);

// File: tb/test_rx_lock_seq.sv
module test_rx_lock_seq;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pll_locked = 1'b0;
   logic [2:0] rate_strap = 3'd0;
   logic [2:0] tracked_rate = 3'd0;
   logic       frame_clk = 1'b0;
   logic       tog_en = 1'b0, tog_lvl = 1'b0, man_lvl = 1'b0;
   logic       serial_in;
   logic       clk_src_recovered, data_mute, unlock;
   logic [2:0] free_rate;
   int         n_run = 0, n_fail = 0;

   assign serial_in = tog_en ? tog_lvl : man_lvl;

   always #2 clk = ~clk;

   rx_lock_seq #(.REF_HZ(40_000), .EDGE_MIN(10), .LOSS_CYC(96),
                 .SYNC_STAGES(2), .HOLD_TRACKED(1'b1)) i_rx_lock_seq (
      .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .pll_locked(pll_locked),
      .rate_strap(rate_strap), .tracked_rate(tracked_rate), .frame_clk(frame_clk),
      .clk_src_recovered(clk_src_recovered), .free_rate(free_rate),
      .data_mute(data_mute), .unlock(unlock)
   );

   // background line toggler: one level change every 4 cycles
   initial forever begin
      repeat (4) @(negedge clk);
      if (tog_en) tog_lvl = ~tog_lvl;
      else        tog_lvl = 1'b0;
   end

   // strap decode vectors {strap, expected rate code}
   localparam logic [5:0] VEC [8] = '{
      {3'd0, 3'd0}, {3'd1, 3'd1}, {3'd2, 3'd2}, {3'd3, 3'd3},
      {3'd4, 3'd4}, {3'd5, 3'd0}, {3'd6, 3'd0}, {3'd7, 3'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tog_en = 1'b0; man_lvl = 1'b0; pll_locked = 1'b0;
      cyc(3);
      rst_n = 1'b1;
      cyc(2);
   endtask

   task automatic pulses(input int n);
      for (int k = 0; k < n; k++) begin
         man_lvl = 1'b1; cyc(4);
         man_lvl = 1'b0; cyc(4);
      end
   endtask

   initial begin
      #400000;
      n_fail++; n_run++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 unlock", unlock, 1);
      chk("R1 mute", data_mute, 1);
      chk("R1 src", clk_src_recovered, 0);

      // R2 strap decode table
      for (int i = 0; i < 8; i++) begin
         rate_strap = VEC[i][5:3];
         cyc(1);
         chk("R2 strap rate", free_rate, VEC[i][2:0]);
      end
      rate_strap = 3'd0;

      // R3 nine edges with PLL high: no lock
      do_reset();
      pll_locked = 1'b1;
      pulses(9);
      cyc(10);
      chk("R3 mute", data_mute, 1);
      chk("R3 src", clk_src_recovered, 0);

      // R5 detected but no PLL lock: stays muted; frame edges keep R1 unlock high
      do_reset();
      tog_en = 1'b1;
      for (int k = 0; k < 8; k++) begin frame_clk = ~frame_clk; cyc(15); end
      chk("R5 mute", data_mute, 1);
      chk("R1 unlock before lock", unlock, 1);

      // R4 lock
      tracked_rate = 3'd3;
      pll_locked = 1'b1;
      cyc(120);
      chk("R4 mute", data_mute, 0);
      chk("R4 src", clk_src_recovered, 1);
      chk("R4 unlock", unlock, 0);

      // R7 loss with frame clock still; R8 unlock waits; R9 held rate
      tog_en = 1'b0;
      cyc(130);
      chk("R7 mute", data_mute, 1);
      chk("R7 src", clk_src_recovered, 0);
      chk("R8 unlock no frame edge", unlock, 0);
      chk("R9 held rate", free_rate, 3);
      frame_clk = ~frame_clk;
      cyc(6);
      chk("R8 unlock after frame edge", unlock, 1);
      chk("R9 held rate stays", free_rate, 3);

      // R10 PLL drop and return
      do_reset();
      tog_en = 1'b1; pll_locked = 1'b1;
      cyc(150);
      chk("R10 locked first", data_mute, 0);
      pll_locked = 1'b0;
      cyc(3);
      chk("R10 mute on drop", data_mute, 1);
      chk("R10 src on drop", clk_src_recovered, 0);
      pll_locked = 1'b1;
      cyc(5);
      chk("R10 relock", data_mute, 0);

      // R6 timeout back to edge counting
      do_reset();
      pulses(10);
      cyc(50);
      pll_locked = 1'b1;
      cyc(15);
      chk("R6 no lock after timeout", data_mute, 1);
      pulses(10);
      cyc(5);
      chk("R6 lock after new edges", data_mute, 0);
      chk("R6 src", clk_src_recovered, 1);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule